// File: doc/BRIEF.md
# 16-bit ALU with Status Word

This block is the arithmetic and logic unit of a 16-bit processor datapath together with its processor status word. Each cycle it combines two 16-bit operands under a 3-bit operation code (add, subtract, AND, OR or XOR) and drives the result combinationally. When flag update is enabled, the six condition flags derived from that result are captured in the status word on the next rising clock edge.

The status word also holds three control flags: string direction, maskable-interrupt enable and single-step trap. Software changes them only through dedicated set and clear strobes. An optional carry-in select turns add into add-with-carry and subtract into subtract-with-borrow, using the stored carry flag. The full 16-bit status word is always visible at the outputs. Its seven unassigned bit positions read as zero.

Top module: `alu16_status`

## Requirements
- R1: `aluResult` is combinational. Operation codes are ADD=0 (a+b), SUB=1 (a-b), AND=2, OR=3, XOR=4, and every result is taken modulo 2^16.
- R2: When `useCarry` is 1, ADD adds the stored carry flag and SUB also subtracts it as a borrow. When `useCarry` is 0 the stored carry has no effect. Logic operations ignore `useCarry`.
- R3: Carry flag (bit 0) is the carry out of bit 15 for ADD and the borrow needed for SUB. Auxiliary carry (bit 4) is the carry out of bit 3 for ADD and the borrow into bit 3 for SUB.
- R4: Overflow flag (bit 11) is set when the carry (or borrow) into bit 15 differs from the carry (or borrow) out of bit 15, which is the same as a two's-complement signed overflow. Adding 0x234D and 0x3211 leaves all six condition flags clear.
- R5: Sign flag (bit 7) equals result bit 15. Zero flag (bit 6) is set exactly when the whole result is 0. Parity flag (bit 2) is set when result bits 7..0 hold an even number of ones.
- R6: AND, OR and XOR clear carry, auxiliary carry and overflow, and update sign, zero and parity.
- R7: Condition flags change only at a rising edge where `flagUpdate` is 1 and the code is 0..4. Codes 5..7 drive a zero result and never change the status word.
- R8: Direction (bit 10), interrupt enable (bit 9) and trap (bit 8) are each set by their own set strobe and cleared by their own clear strobe at the next edge, independently of `flagUpdate`. If a flag's set and clear strobes are both asserted, set wins.
- R9: After reset the status word is 0x0000. Bits 1, 3, 5 and 15..12 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand (subtrahend for SUB) |
| opCode | input | 3 | Operation select, 0..4 valid |
| useCarry | input | 1 | Fold stored carry into ADD / SUB |
| flagUpdate | input | 1 | Capture condition flags at the next edge |
| dirSet | input | 1 | Set direction flag |
| dirClr | input | 1 | Clear direction flag |
| intSet | input | 1 | Set interrupt-enable flag |
| intClr | input | 1 | Clear interrupt-enable flag |
| trapSet | input | 1 | Set trap flag |
| trapClr | input | 1 | Clear trap flag |
| aluResult | output | 16 | Operation result |
| statusWord | output | 16 | Processor status word |

## Verification
The assertions check on every cycle that the unassigned status bits stay zero, that captured sign and zero follow the previous result, and that logic operations leave carry, auxiliary carry and overflow clear. They also check that condition flags hold whenever no valid update occurs, that a set strobe always wins, and that invalid codes give a zero result. Only the bench scenarios can show the correctness of the carry, borrow, nibble-carry and overflow values themselves, and the effect of the carry-in select against a stored flag. They also show the fixed all-clear addition case and the parity count, which the bench's behavioural model compares every clock across directed corner operands and a long random sequence.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int WORD_W   = 16;
  localparam int NIBBLE_W = 4;
  localparam int PAR_W    = 8;
  localparam int OPC_W    = 3;

  // status word bit positions
  localparam int POS_CF = 0;
  localparam int POS_PF = 2;
  localparam int POS_AF = 4;
  localparam int POS_ZF = 6;
  localparam int POS_SF = 7;
  localparam int POS_TF = 8;
  localparam int POS_IF = 9;
  localparam int POS_DF = 10;
  localparam int POS_OF = 11;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD = 3'd0,
    OPC_SUB = 3'd1,
    OPC_AND = 3'd2,
    OPC_OR  = 3'd3,
    OPC_XOR = 3'd4
  } aluOpc_e;

  typedef enum logic [1:0] {
    LSEL_AND  = 2'd0,
    LSEL_OR   = 2'd1,
    LSEL_XOR  = 2'd2,
    LSEL_ZERO = 2'd3
  } logicSel_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } condFlags_t;

  typedef struct packed {
    logic      doSub;
    logic      doLogic;
    logicSel_e logicSel;
    logic      carryIn;
    logic      condWr;
    logic      dirWr;
    logic      dirVal;
    logic      ieWr;
    logic      ieVal;
    logic      tfWr;
    logic      tfVal;
  } aluStrobe_t;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
#(
  parameter int OPC_BITS = OPC_W
) (
  input  logic [OPC_BITS-1:0] opCode,
  input  logic                useCarry,
  input  logic                flagUpdate,
  input  logic                curCarry,
  input  logic                dirSet,
  input  logic                dirClr,
  input  logic                intSet,
  input  logic                intClr,
  input  logic                trapSet,
  input  logic                trapClr,
  output aluStrobe_t          strobe
);

  localparam int NUM_CTRL = 3;

  logic isArith;
  logic isValid;
  logic [NUM_CTRL-1:0] setVec;
  logic [NUM_CTRL-1:0] clrVec;
  logic [NUM_CTRL-1:0] wrVec;
  logic [NUM_CTRL-1:0] valVec;

  assign setVec = {trapSet, intSet, dirSet};
  assign clrVec = {trapClr, intClr, dirClr};

  // one write/value pair per control flag; set has priority over clear
  for (genvar i = 0; i < NUM_CTRL; i++) begin : gCtrlFlag
    assign wrVec[i]  = setVec[i] | clrVec[i];
    assign valVec[i] = setVec[i];
  end

  always_comb begin
    isArith = 1'b0;
    isValid = 1'b1;
    strobe  = '0;
    strobe.logicSel = LSEL_ZERO;
    case (opCode)
      OPC_ADD: begin
        isArith      = 1'b1;
        strobe.doSub = 1'b0;
      end
      OPC_SUB: begin
        isArith      = 1'b1;
        strobe.doSub = 1'b1;
      end
      OPC_AND: begin
        strobe.doLogic  = 1'b1;
        strobe.logicSel = LSEL_AND;
      end
      OPC_OR: begin
        strobe.doLogic  = 1'b1;
        strobe.logicSel = LSEL_OR;
      end
      OPC_XOR: begin
        strobe.doLogic  = 1'b1;
        strobe.logicSel = LSEL_XOR;
      end
      default: begin
        isValid         = 1'b0;
        strobe.doLogic  = 1'b1;
        strobe.logicSel = LSEL_ZERO;
      end
    endcase
    strobe.carryIn = isArith & useCarry & curCarry;
    strobe.condWr  = isValid & flagUpdate;
    strobe.dirWr   = wrVec[0];
    strobe.dirVal  = valVec[0];
    strobe.ieWr    = wrVec[1];
    strobe.ieVal   = valVec[1];
    strobe.tfWr    = wrVec[2];
    strobe.tfVal   = valVec[2];
  end

endmodule

// File: rtl/alu16_dp.sv
module alu16_dp
  import alu16_pkg::*;
#(
  parameter int W   = WORD_W,
  parameter int NIB = NIBBLE_W,
  parameter int PW  = PAR_W
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluStrobe_t   strobe,
  output logic [W-1:0] result,
  output condFlags_t   flagsNext
);

  localparam int LOW_W = W - 1;

  logic [W-1:0]     bEff;
  logic             cIn;
  logic [W:0]       fullSum;
  logic [LOW_W:0]   lowSum;
  logic [NIB:0]     nibSum;
  logic [W-1:0]     logicRes;
  logic             carryOut;
  logic             carryIntoMsb;
  logic             nibCarry;

  // subtraction as a + ~b + ~borrowIn; carries then read as inverted borrows
  assign bEff = strobe.doSub ? ~opB : opB;
  assign cIn  = strobe.doSub ? ~strobe.carryIn : strobe.carryIn;

  assign fullSum = {1'b0, opA} + {1'b0, bEff} + {{W{1'b0}}, cIn};
  assign lowSum  = {1'b0, opA[LOW_W-1:0]} + {1'b0, bEff[LOW_W-1:0]} + {{LOW_W{1'b0}}, cIn};
  assign nibSum  = {1'b0, opA[NIB-1:0]} + {1'b0, bEff[NIB-1:0]} + {{NIB{1'b0}}, cIn};

  assign carryOut     = fullSum[W];
  assign carryIntoMsb = lowSum[LOW_W];
  assign nibCarry     = nibSum[NIB];

  always_comb begin
    unique case (strobe.logicSel)
      LSEL_AND: logicRes = opA & opB;
      LSEL_OR:  logicRes = opA | opB;
      LSEL_XOR: logicRes = opA ^ opB;
      default:  logicRes = '0;
    endcase
  end

  assign result = strobe.doLogic ? logicRes : fullSum[W-1:0];

  always_comb begin
    flagsNext.sf = result[W-1];
    flagsNext.zf = ~|result;
    flagsNext.pf = ~^result[PW-1:0];
    if (strobe.doLogic) begin
      flagsNext.cf = 1'b0;
      flagsNext.af = 1'b0;
      flagsNext.of = 1'b0;
    end else begin
      flagsNext.cf = carryOut ^ strobe.doSub;
      flagsNext.af = nibCarry ^ strobe.doSub;
      flagsNext.of = carryIntoMsb ^ carryOut;
    end
  end

endmodule

// File: rtl/alu16_psw.sv
module alu16_psw
  import alu16_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  aluStrobe_t   strobe,
  input  condFlags_t   flagsNext,
  output logic         curCarry,
  output logic [W-1:0] statusWord
);

  condFlags_t condQ;
  logic dirQ;
  logic ieQ;
  logic tfQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condQ <= '0;
    end else if (strobe.condWr) begin
      condQ <= flagsNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= 1'b0;
      ieQ  <= 1'b0;
      tfQ  <= 1'b0;
    end else begin
      if (strobe.dirWr) dirQ <= strobe.dirVal;
      if (strobe.ieWr)  ieQ  <= strobe.ieVal;
      if (strobe.tfWr)  tfQ  <= strobe.tfVal;
    end
  end

  assign curCarry = condQ.cf;

  always_comb begin
    statusWord         = '0;
    statusWord[POS_CF] = condQ.cf;
    statusWord[POS_PF] = condQ.pf;
    statusWord[POS_AF] = condQ.af;
    statusWord[POS_ZF] = condQ.zf;
    statusWord[POS_SF] = condQ.sf;
    statusWord[POS_TF] = tfQ;
    statusWord[POS_IF] = ieQ;
    statusWord[POS_DF] = dirQ;
    statusWord[POS_OF] = condQ.of;
  end

endmodule

// File: rtl/alu16_status.sv
module alu16_status
  import alu16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic [2:0]  opCode,
  input  logic        useCarry,
  input  logic        flagUpdate,
  input  logic        dirSet,
  input  logic        dirClr,
  input  logic        intSet,
  input  logic        intClr,
  input  logic        trapSet,
  input  logic        trapClr,
  output logic [15:0] aluResult,
  output logic [15:0] statusWord
);

  aluStrobe_t strobe;
  condFlags_t flagsNext;
  logic       curCarry;

  alu16_ctrl #(.OPC_BITS(OPC_W)) u_ctrl (
    .opCode    (opCode),
    .useCarry  (useCarry),
    .flagUpdate(flagUpdate),
    .curCarry  (curCarry),
    .dirSet    (dirSet),
    .dirClr    (dirClr),
    .intSet    (intSet),
    .intClr    (intClr),
    .trapSet   (trapSet),
    .trapClr   (trapClr),
    .strobe    (strobe)
  );

  alu16_dp #(.W(WORD_W), .NIB(NIBBLE_W), .PW(PAR_W)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .strobe   (strobe),
    .result   (aluResult),
    .flagsNext(flagsNext)
  );

  alu16_psw #(.W(WORD_W)) u_psw (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .flagsNext (flagsNext),
    .curCarry  (curCarry),
    .statusWord(statusWord)
  );

endmodule

// File: rtl/alu16_status_chk.sv
module alu16_status_chk (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  opCode,
  input logic        flagUpdate,
  input logic        dirSet,
  input logic        intSet,
  input logic        trapSet,
  input logic [15:0] aluResult,
  input logic [15:0] statusWord
);

  localparam logic [15:0] UNUSED_MASK = 16'hF02A;
  localparam logic [15:0] COND_MASK   = 16'h08D5;

  logic validUpd;
  logic logicUpd;
  assign validUpd = flagUpdate && (opCode <= 3'd4);
  assign logicUpd = flagUpdate && (opCode >= 3'd2) && (opCode <= 3'd4);

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord & UNUSED_MASK) == 16'h0000); // R9

  AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    validUpd |=> statusWord[7] == $past(aluResult[15])); // R5

  AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    validUpd |=> statusWord[6] == ($past(aluResult) == 16'h0000)); // R5

  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    logicUpd |=> (!statusWord[0] && !statusWord[4] && !statusWord[11])); // R6

  AST_COND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !validUpd |=> $stable(statusWord & COND_MASK)); // R7

  AST_BADOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (opCode > 3'd4) |-> aluResult == 16'h0000); // R7

  AST_DIR_SET: assert property (@(posedge clk) disable iff (!rstN)
    dirSet |=> statusWord[10]); // R8

  AST_INT_SET: assert property (@(posedge clk) disable iff (!rstN)
    intSet |=> statusWord[9]); // R8

  AST_TRAP_SET: assert property (@(posedge clk) disable iff (!rstN)
    trapSet |=> statusWord[8]); // R8

endmodule

bind alu16_status alu16_status_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opCode    (opCode),
  .flagUpdate(flagUpdate),
  .dirSet    (dirSet),
  .intSet    (intSet),
  .trapSet   (trapSet),
  .aluResult (aluResult),
  .statusWord(statusWord)
);

// File: tb/tb_alu16_status.sv
`timescale 1ns/1ps
module tb_alu16_status;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [2:0]  opCode = '0;
  logic        useCarry = 1'b0;
  logic        flagUpdate = 1'b0;
  logic        dirSet = 1'b0, dirClr = 1'b0;
  logic        intSet = 1'b0, intClr = 1'b0;
  logic        trapSet = 1'b0, trapClr = 1'b0;
  logic [15:0] aluResult;
  logic [15:0] statusWord;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // behavioural model state
  int mCf = 0, mPf = 0, mAf = 0, mZf = 0, mSf = 0, mOf = 0;
  int mDf = 0, mIe = 0, mTf = 0;

  always #10 clk = ~clk;

  alu16_status dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opCode(opCode),
    .useCarry(useCarry), .flagUpdate(flagUpdate),
    .dirSet(dirSet), .dirClr(dirClr), .intSet(intSet), .intClr(intClr),
    .trapSet(trapSet), .trapClr(trapClr),
    .aluResult(aluResult), .statusWord(statusWord)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", tag, what, act, exp);
    end
  endtask

  function automatic int modelWord();
    return mCf | (mPf << 2) | (mAf << 4) | (mZf << 6) | (mSf << 7) |
           (mTf << 8) | (mIe << 9) | (mDf << 10) | (mOf << 11);
  endfunction

  function automatic int sgn(input int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  // one clock: drive, check result, advance model, check status
  task automatic step(input int op, input int a, input int b, input bit uc, input bit fu,
                      input bit ds, input bit dc, input bit is, input bit ic,
                      input bit ts, input bit tc, input string tag);
    int c, raw, res, cf, af, ofl, sres, ones;
    @(negedge clk);
    opA = a[15:0]; opB = b[15:0]; opCode = op[2:0]; useCarry = uc; flagUpdate = fu;
    dirSet = ds; dirClr = dc; intSet = is; intClr = ic; trapSet = ts; trapClr = tc;
    #1;
    c = uc ? mCf : 0;
    cf = 0; af = 0; ofl = 0;
    case (op)
      0: begin
        raw = a + b + c; res = raw % 65536; cf = (raw > 65535);
        af = (((a % 16) + (b % 16) + c) > 15);
        sres = sgn(a) + sgn(b) + c; ofl = (sres > 32767) || (sres < -32768);
      end
      1: begin
        raw = a - b - c; res = (raw + 65536) % 65536; cf = (raw < 0);
        af = (((a % 16) - (b % 16) - c) < 0);
        sres = sgn(a) - sgn(b) - c; ofl = (sres > 32767) || (sres < -32768);
      end
      2: res = a & b;
      3: res = a | b;
      4: res = a ^ b;
      default: res = 0;
    endcase
    check(tag, "result", int'(aluResult), res);
    if (fu && op <= 4) begin
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (res >> i) & 1;
      mCf = cf; mAf = af; mOf = ofl;
      mSf = (res >> 15) & 1; mZf = (res == 0); mPf = (ones % 2 == 0);
    end
    if (ds || dc) mDf = ds;
    if (is || ic) mIe = is;
    if (ts || tc) mTf = ts;
    @(posedge clk);
    #1;
    check(tag, "status", int'(statusWord), modelWord());
  endtask

  task automatic arith(input int op, input int a, input int b, input bit uc, input string tag);
    step(op, a, b, uc, 1, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9", "reset status", int'(statusWord), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R4: fixed all-clear addition
    arith(0, 16'h234D, 16'h3211, 0, "R4");
    check("R4", "flags clear", int'(statusWord), 0);
    // R3 / R4 / R5 add corners
    arith(0, 16'hFFFF, 16'h0001, 0, "R3");
    arith(0, 16'h7FFF, 16'h0001, 0, "R4");
    arith(0, 16'h8000, 16'h8000, 0, "R4");
    arith(0, 16'h0008, 16'h0008, 0, "R3");
    // subtraction corners
    arith(1, 16'h0000, 16'h0001, 0, "R3");
    arith(1, 16'h8000, 16'h0001, 0, "R4");
    arith(1, 16'h7FFF, 16'hFFFF, 0, "R4");
    arith(1, 16'h1234, 16'h1234, 0, "R5");
    arith(1, 16'h0010, 16'h0001, 0, "R3");
    // R2 carry-in select: produce CF=1 then fold it
    arith(0, 16'hFFFF, 16'h0002, 0, "R2");
    arith(0, 16'h0001, 16'h0001, 1, "R2");
    arith(1, 16'h0000, 16'h0001, 0, "R2");
    arith(1, 16'h0005, 16'h0002, 1, "R2");
    arith(1, 16'h0000, 16'h0001, 0, "R2");
    arith(0, 16'h0010, 16'h0020, 0, "R2");
    // R6 logic clears CF/AF/OF after they were set
    arith(0, 16'h7FFF, 16'h0001, 0, "R6");
    arith(2, 16'hF0F0, 16'h8F0F, 0, "R6");
    arith(1, 16'h8000, 16'h0001, 0, "R6");
    arith(3, 16'h0000, 16'h0000, 1, "R6");
    arith(0, 16'hFFFF, 16'h0001, 0, "R6");
    arith(4, 16'hA5A5, 16'h5A5A, 0, "R6");
    // R1 plain results
    arith(2, 16'h1234, 16'h0FF0, 0, "R1");
    arith(3, 16'h1200, 16'h0034, 0, "R1");
    arith(4, 16'hFFFF, 16'h00FF, 0, "R1");
    arith(0, 16'hABCD, 16'h1111, 0, "R1");
    // R5 parity on low byte only
    arith(4, 16'h0103, 16'h0000, 0, "R5");
    arith(4, 16'hFF07, 16'h0000, 0, "R5");
    // R7 no update without enable, and bad codes
    arith(0, 16'hFFFF, 16'h0001, 0, "R7");
    step(1, 16'h0000, 16'h0001, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 16'h0001, 16'h0001, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(5, 16'hFFFF, 16'hFFFF, 0, 1, 0, 0, 0, 0, 0, 0, "R7");
    step(6, 16'h1234, 16'h4321, 1, 1, 0, 0, 0, 0, 0, 0, "R7");
    step(7, 16'h8000, 16'h0000, 0, 1, 0, 0, 0, 0, 0, 0, "R7");
    // R8 control flags
    step(2, 16'h0000, 16'h0000, 0, 0, 1, 0, 0, 0, 0, 0, "R8");
    step(2, 16'h0000, 16'h0000, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
    step(2, 16'h0000, 16'h0000, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
    step(0, 16'h7FFF, 16'h0001, 0, 1, 0, 1, 0, 0, 0, 0, "R8");
    step(2, 16'h0000, 16'h0000, 0, 0, 0, 0, 1, 1, 0, 1, "R8");
    step(2, 16'h0000, 16'h0000, 0, 0, 1, 1, 0, 1, 1, 1, "R8");
    step(4, 16'h0001, 16'h0000, 0, 1, 0, 1, 0, 0, 0, 1, "R8");
    // random mix, R9 word layout checked by the model every step
    for (int k = 0; k < 400; k++) begin
      step(int'($urandom_range(0, 7)), int'($urandom_range(0, 65535)),
           int'($urandom_range(0, 65535)), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 3) != 0),
           bit'($urandom_range(0, 7) == 0), bit'($urandom_range(0, 7) == 0),
           bit'($urandom_range(0, 7) == 0), bit'($urandom_range(0, 7) == 0),
           bit'($urandom_range(0, 7) == 0), bit'($urandom_range(0, 7) == 0), "R9");
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule